// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block searches and extends the singly linked chain of extended capability headers kept in the upper part of a 4 KB configuration space. It reaches that space through a single 32-bit RAM port, one dword access per cycle, with read data returned one cycle after the read strobe. Each node of the chain is one header dword: the capability identifier in bits 15:0, a 4-bit version in bits 19:16 and a 12-bit byte offset of the next node in bits 31:20. A next offset of zero terminates the chain, and the chain always starts at byte offset 256.

A client issues one request at a time. A lookup names a 16-bit identifier. The block follows the chain until it finds a node with that identifier or reaches the end, and it reports the offset where it stopped together with the node visited before it. An insertion names an identifier, a version, a byte offset and a body size. The block finds the last node by searching for the reserved identifier zero, points that node's next field at the new offset and writes the new header with a zero next field. An insertion at offset 256 itself replaces the head header and keeps the next pointer already stored there. Malformed chains (bad pointers, or a loop that exceeds the hop limit) and out-of-range insertions end the request with an error flag.

Top module: `ecap_walker`

## Requirements
- R1: After reset, busy, done and err are 0 and neither mem_rd_en nor mem_wr_en is asserted.
- R2: A lookup where the dword at byte offset 256 is all zeros completes with res_off = 0, res_prev = 0 and err = 0.
- R3: A lookup that meets a node whose bits 15:0 equal req_id returns that node's byte offset in res_off and the byte offset of the node visited before it in res_prev (0 when the hit is the node at 256).
- R4: A lookup that reaches a node whose next field (bits 31:20) is 0 without a hit returns res_off = 0 and res_prev = the byte offset of that last node.
- R5: The walk follows bits 31:20 of each header as the next byte offset and compares only bits 15:0 with the searched identifier; bits 19:16 do not influence the result.
- R6: A next pointer below 256, above 4088, or not a multiple of 4 aborts the request with err = 1, res_off = 0 and res_prev = 0; the block never reads outside word addresses 64 to 1022.
- R7: A chain that would need more than HOP_LIMIT header reads (for example a loop) aborts with err = 1.
- R8: An insertion at an offset other than 256 rewrites the last node's header with bits 31:20 set to the new offset and bits 19:0 unchanged, writes {12'h000, req_ver, req_id} at the new offset, and returns res_off = new offset and res_prev = last node's offset.
- R9: An insertion at offset 256 reads only the head header and writes {old bits 31:20, req_ver, req_id} at 256, returning res_off = 256, res_prev = 0.
- R10: An insertion with req_size < 8, req_off + req_size >= 4096, req_off < 256, req_off not a multiple of 4, into an empty chain at an offset other than 256, or into a chain holding a node with identifier 0 before its end, ends with err = 1 and writes nothing.
- R11: done is a one-cycle pulse with busy already low; results and err hold until the next accepted request, and req_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_append | input | 1 | 1 = insertion, 0 = lookup |
| req_id | input | 16 | Capability identifier |
| req_ver | input | 4 | Version for an insertion |
| req_off | input | 12 | Byte offset for an insertion |
| req_size | input | 13 | Body size in bytes for an insertion |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request ended in error |
| res_off | output | 12 | Offset where the walk stopped / inserted offset |
| res_prev | output | 12 | Offset of the preceding node |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_addr | output | 10 | RAM dword address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid one cycle after mem_rd_en |

## Verification
Lookups run over a three-node chain for an identifier at the head, in the middle, at the tail and absent, which separates the hit-offset and predecessor paths from the end-of-chain path; the version field differs between nodes so a comparison that looked at it would miss. Broken chains with a pointer below the start, one past the top bound, one misaligned and a two-node loop tell apart the three pointer checks and the hop limit. Insertions at the tail, at the head, into an empty chain and with each bad parameter show which words are rewritten and that a refused insertion leaves memory alone, and a request strobed while busy shows that it is dropped.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int OFF_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_EVAL  = 3'd2,
        ST_WTAIL = 3'd3,
        ST_WNEW  = 3'd4
    } walk_state_e;

    typedef struct packed {
        walk_state_e        st;
        logic               busy;
        logic               done;
        logic               err;
        logic               append;
        logic               head;
        logic               first;
        logic [15:0]        id;
        logic [15:0]        target;
        logic [3:0]         ver;
        logic [OFF_W-1:0]   off;
        logic [OFF_W-1:0]   cur;
        logic [OFF_W-1:0]   prev;
        logic [OFF_W-1:0]   new_next;
        logic [OFF_W-1:0]   res_off;
        logic [OFF_W-1:0]   res_prev;
        logic [19:0]        tail_low;
    } walk_regs_t;

    function automatic logic [31:0] hdr_pack(input logic [OFF_W-1:0] nxt,
                                             input logic [3:0] ver,
                                             input logic [15:0] id);
        return {nxt, ver, id};
    endfunction

endpackage

// File: rtl/ecap_ptr_check.sv
module ecap_ptr_check #(
    parameter int OFF_W       = 12,
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096
) (
    input  logic [OFF_W-1:0] ptr,
    output logic             ok
);
    localparam logic [OFF_W-1:0] LO = OFF_W'(BASE_OFF);
    localparam logic [OFF_W-1:0] HI = OFF_W'(SPACE_BYTES - 8);

    always_comb begin
        ok = (ptr >= LO) && (ptr <= HI) && (ptr[1:0] == 2'b00);
    end
endmodule

// File: rtl/ecap_req_check.sv
module ecap_req_check #(
    parameter int OFF_W       = 12,
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096,
    parameter int MIN_SIZE    = 8
) (
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W:0]   size,
    output logic             ok
);
    localparam int SUM_W = OFF_W + 2;
    localparam logic [OFF_W-1:0] LO    = OFF_W'(BASE_OFF);
    localparam logic [OFF_W:0]   MINSZ = (OFF_W+1)'(MIN_SIZE);
    localparam logic [SUM_W-1:0] TOP   = SUM_W'(SPACE_BYTES);

    logic [SUM_W-1:0] end_byte;

    always_comb begin
        end_byte = SUM_W'(off) + SUM_W'(size);
        ok = (off >= LO) && (off[1:0] == 2'b00) && (size >= MINSZ) && (end_byte < TOP);
    end
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
    import ecap_pkg::*;
#(
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096,
    parameter int HOP_LIMIT   = 1024,
    parameter int MIN_SIZE    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_append,
    input  logic [15:0] req_id,
    input  logic [3:0]  req_ver,
    input  logic [11:0] req_off,
    input  logic [12:0] req_size,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [11:0] res_off,
    output logic [11:0] res_prev,
    output logic        mem_rd_en,
    output logic        mem_wr_en,
    output logic [9:0]  mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    localparam int HOP_W = $clog2(HOP_LIMIT + 1);
    localparam logic [OFF_W-1:0] BASE = OFF_W'(BASE_OFF);
    localparam logic [HOP_W-1:0] HOP_MAX = HOP_W'(HOP_LIMIT);

    walk_regs_t s_d, s_q;
    logic [HOP_W-1:0] hops_d, hops_q;

    logic [OFF_W-1:0] hdr_next;
    logic [15:0]      hdr_id;
    logic             ptr_ok;
    logic             req_ok;

    assign hdr_next = mem_rdata[31:20];
    assign hdr_id   = mem_rdata[15:0];

    ecap_ptr_check #(
        .OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .SPACE_BYTES(SPACE_BYTES)
    ) u_ptr_check (
        .ptr (hdr_next),
        .ok  (ptr_ok)
    );

    ecap_req_check #(
        .OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .SPACE_BYTES(SPACE_BYTES), .MIN_SIZE(MIN_SIZE)
    ) u_req_check (
        .off  (req_off),
        .size (req_size),
        .ok   (req_ok)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        hops_d    = hops_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = s_q.cur[OFF_W-1:2];
        mem_wdata = '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.busy     = 1'b1;
                    s_d.err      = 1'b0;
                    s_d.res_off  = '0;
                    s_d.res_prev = '0;
                    s_d.append   = req_append;
                    s_d.id       = req_id;
                    s_d.ver      = req_ver;
                    s_d.off      = req_off;
                    s_d.cur      = BASE;
                    s_d.prev     = '0;
                    s_d.first    = 1'b1;
                    s_d.head     = req_append && (req_off == BASE);
                    s_d.target   = req_append ? 16'h0000 : req_id;
                    hops_d       = HOP_W'(1);
                    if (req_append && !req_ok) begin
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else begin
                        s_d.st = ST_READ;
                    end
                end
            end

            ST_READ: begin
                mem_rd_en = 1'b1;
                mem_addr  = s_q.cur[OFF_W-1:2];
                s_d.st    = ST_EVAL;
            end

            ST_EVAL: begin
                s_d.first = 1'b0;
                if (s_q.head) begin
                    // head insertion: keep the stored link, replace id/version
                    s_d.new_next = hdr_next;
                    s_d.res_off  = s_q.off;
                    s_d.res_prev = '0;
                    s_d.st       = ST_WNEW;
                end else if (s_q.first && (mem_rdata == 32'h0)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                    s_d.err  = s_q.append;
                end else if (hdr_id == s_q.target) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                    if (s_q.append) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.res_off  = s_q.cur;
                        s_d.res_prev = s_q.prev;
                    end
                end else if (hdr_next == '0) begin
                    if (s_q.append) begin
                        s_d.tail_low = mem_rdata[19:0];
                        s_d.prev     = s_q.cur;
                        s_d.new_next = '0;
                        s_d.res_off  = s_q.off;
                        s_d.res_prev = s_q.cur;
                        s_d.st       = ST_WTAIL;
                    end else begin
                        s_d.busy     = 1'b0;
                        s_d.done     = 1'b1;
                        s_d.st       = ST_IDLE;
                        s_d.res_off  = '0;
                        s_d.res_prev = s_q.cur;
                    end
                end else if (!ptr_ok || (hops_q >= HOP_MAX)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.prev = s_q.cur;
                    s_d.cur  = hdr_next;
                    hops_d   = hops_q + HOP_W'(1);
                    s_d.st   = ST_READ;
                end
            end

            ST_WTAIL: begin
                mem_wr_en = 1'b1;
                mem_addr  = s_q.prev[OFF_W-1:2];
                mem_wdata = {s_q.off, s_q.tail_low};
                s_d.st    = ST_WNEW;
            end

            ST_WNEW: begin
                mem_wr_en = 1'b1;
                mem_addr  = s_q.off[OFF_W-1:2];
                mem_wdata = hdr_pack(s_q.new_next, s_q.ver, s_q.id);
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.st    = ST_IDLE;
            end

            default: begin
                s_d.st   = ST_IDLE;
                s_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            hops_q <= '0;
        end else begin
            s_q    <= s_d;
            hops_q <= hops_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign err      = s_q.err;
    assign res_off  = s_q.res_off;
    assign res_prev = s_q.res_prev;

endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
    parameter int BASE_OFF    = 256,
    parameter int SPACE_BYTES = 4096
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [11:0] res_off,
    input logic [11:0] res_prev,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [9:0]  mem_addr
);
    localparam logic [9:0] WLO = 10'(BASE_OFF / 4);
    localparam logic [9:0] WHI = 10'((SPACE_BYTES - 8) / 4);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R8

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((mem_addr >= WLO) && (mem_addr <= WHI))); // R6

    AST_ERR_CLEAR_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ((res_off == 12'h000) && (res_prev == 12'h000))); // R6

    AST_ERR_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R11
endmodule

bind ecap_walker ecap_walker_chk #(
    .BASE_OFF(BASE_OFF), .SPACE_BYTES(SPACE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .res_off(res_off), .res_prev(res_prev),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/tb_ecap_walker.sv
module tb_ecap_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 1024;
    localparam int HOPS       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_append = 1'b0;
    logic [15:0] req_id = '0;
    logic [3:0]  req_ver = '0;
    logic [11:0] req_off = '0;
    logic [12:0] req_size = '0;
    logic        busy, done, err;
    logic [11:0] res_off, res_prev;
    logic        mem_rd_en, mem_wr_en;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] ram [0:WORDS-1];
    logic        tb_clr = 1'b0, tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;

    int checks = 0, failures = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecap_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_append(req_append),
        .req_id(req_id), .req_ver(req_ver), .req_off(req_off), .req_size(req_size),
        .busy(busy), .done(done), .err(err), .res_off(res_off), .res_prev(res_prev),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < WORDS; i++) ram[i] <= 32'h0;
        end else if (tb_we) begin
            ram[tb_wa] <= tb_wd;
        end else if (mem_wr_en) begin
            ram[mem_addr] <= mem_wdata;
        end
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
                summary_and_end();
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_ram();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic poke(input int byte_off, input logic [31:0] data);
        @(negedge clk); tb_we = 1'b1; tb_wa = 10'(byte_off / 4); tb_wd = data;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic start_req(input logic app, input logic [15:0] id, input logic [3:0] ver,
                             input logic [11:0] off, input logic [12:0] size);
        @(negedge clk);
        req_valid = 1'b1; req_append = app; req_id = id; req_ver = ver;
        req_off = off; req_size = size;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_req(input logic app, input logic [15:0] id, input logic [3:0] ver,
                           input logic [11:0] off, input logic [12:0] size);
        start_req(app, id, ver, off, size);
        wait_done();
    endtask

    // standard chain: 256 -> 320 -> 512, versions differ
    task automatic build_std();
        clear_ram();
        poke(256, {12'h140, 4'h1, 16'h0001});
        poke(320, {12'h200, 4'h3, 16'h000E});
        poke(512, {12'h000, 4'h2, 16'h0018});
    endtask

    // reference lookup walked over the bench copy of the RAM
    task automatic ref_find(input logic [15:0] id, output logic [11:0] off,
                            output logic [11:0] prev, output logic bad);
        logic [11:0] cur = 12'h100;
        logic [11:0] pv = 12'h000;
        logic [31:0] h;
        off = 0; prev = 0; bad = 0;
        if (ram[64] == 32'h0) return;
        for (int k = 1; k <= HOPS + 1; k++) begin
            h = ram[cur[11:2]];
            if (h[15:0] == id) begin off = cur; prev = pv; return; end
            if (h[31:20] == 12'h0) begin off = 0; prev = cur; return; end
            if (h[31:20] < 12'h100 || h[31:20] > 12'hFF8 || h[21:20] != 2'b00 || k >= HOPS) begin
                bad = 1; return;
            end
            pv = cur; cur = h[31:20];
        end
    endtask

    // id, expected offset, expected previous
    localparam logic [39:0] TV [0:3] = '{
        {16'h0001, 12'h100, 12'h000},
        {16'h000E, 12'h140, 12'h100},
        {16'h0018, 12'h200, 12'h140},
        {16'h0023, 12'h000, 12'h200}
    };

    initial begin
        logic [11:0] r_off, r_prev;
        logic        r_bad;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 done", {31'h0, done}, 32'h0);
        check("R1 mem strobes", {30'h0, mem_rd_en, mem_wr_en}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        check("R1 err", {31'h0, err}, 32'h0);

        // R3 R4 R5: table of lookups over the standard chain
        build_std();
        for (int t = 0; t < 4; t++) begin
            run_req(1'b0, TV[t][39:24], 4'h0, 12'h0, 13'h0);
            ref_find(TV[t][39:24], r_off, r_prev, r_bad);
            check("R3_R4 res_off", {20'h0, res_off}, {20'h0, TV[t][23:12]});
            check("R3_R4 res_prev", {20'h0, res_prev}, {20'h0, TV[t][11:0]});
            check("R5 ref off", {20'h0, res_off}, {20'h0, r_off});
            check("R5 err", {31'h0, err}, {31'h0, r_bad});
        end

        // R2: empty chain
        clear_ram();
        poke(320, {12'h000, 4'h1, 16'h0005});
        run_req(1'b0, 16'h0005, 4'h0, 12'h0, 13'h0);
        check("R2 off", {20'h0, res_off}, 32'h0);
        check("R2 prev", {20'h0, res_prev}, 32'h0);
        check("R2 err", {31'h0, err}, 32'h0);

        // R6: pointer below start
        clear_ram();
        poke(256, {12'h0FC, 4'h1, 16'h0001});
        run_req(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0);
        check("R6 low ptr err", {31'h0, err}, 32'h1);
        check("R6 low ptr off", {20'h0, res_off}, 32'h0);
        // R6: pointer above top bound
        poke(256, {12'hFFC, 4'h1, 16'h0001});
        run_req(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0);
        check("R6 high ptr err", {31'h0, err}, 32'h1);
        // R6: misaligned pointer
        poke(256, {12'h142, 4'h1, 16'h0001});
        run_req(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0);
        check("R6 misaligned err", {31'h0, err}, 32'h1);
        // top bound 4088 itself is legal
        poke(256, {12'hFF8, 4'h1, 16'h0001});
        poke(4088, {12'h000, 4'h1, 16'h0042});
        run_req(1'b0, 16'h0042, 4'h0, 12'h0, 13'h0);
        check("R6 edge ptr off", {20'h0, res_off}, 32'hFF8);
        check("R6 edge ptr err", {31'h0, err}, 32'h0);

        // R7: loop 256 <-> 260
        clear_ram();
        poke(256, {12'h104, 4'h1, 16'h0001});
        poke(260, {12'h100, 4'h1, 16'h0002});
        run_req(1'b0, 16'h0077, 4'h0, 12'h0, 13'h0);
        check("R7 loop err", {31'h0, err}, 32'h1);
        check("R7 loop done seen", {31'h0, done}, 32'h1);

        // R8: insertion at the tail
        build_std();
        run_req(1'b1, 16'h0010, 4'h1, 12'h300, 13'd16);
        check("R8 err", {31'h0, err}, 32'h0);
        check("R8 res_off", {20'h0, res_off}, 32'h300);
        check("R8 res_prev", {20'h0, res_prev}, 32'h200);
        @(negedge clk);
        check("R8 tail rewritten", ram[128], {12'h300, 4'h2, 16'h0018});
        check("R8 new header", ram[192], {12'h000, 4'h1, 16'h0010});
        check("R8 head untouched", ram[64], {12'h140, 4'h1, 16'h0001});
        run_req(1'b0, 16'h0010, 4'h0, 12'h0, 13'h0);
        check("R8 lookup inserted", {20'h0, res_off}, 32'h300);
        check("R8 lookup inserted prev", {20'h0, res_prev}, 32'h200);

        // R9: insertion at the head keeps the stored link
        build_std();
        run_req(1'b1, 16'h0055, 4'h3, 12'h100, 13'd8);
        check("R9 err", {31'h0, err}, 32'h0);
        check("R9 res_off", {20'h0, res_off}, 32'h100);
        check("R9 res_prev", {20'h0, res_prev}, 32'h0);
        @(negedge clk);
        check("R9 head header", ram[64], {12'h140, 4'h3, 16'h0055});
        check("R9 tail untouched", ram[128], {12'h000, 4'h2, 16'h0018});

        // R10: refused insertions write nothing
        build_std();
        run_req(1'b1, 16'h0061, 4'h1, 12'h300, 13'd4);
        check("R10 small size err", {31'h0, err}, 32'h1);
        run_req(1'b1, 16'h0062, 4'h1, 12'hFF0, 13'd16);
        check("R10 end at 4096 err", {31'h0, err}, 32'h1);
        run_req(1'b1, 16'h0063, 4'h1, 12'h302, 13'd8);
        check("R10 misaligned err", {31'h0, err}, 32'h1);
        run_req(1'b1, 16'h0064, 4'h1, 12'h0F0, 13'd8);
        check("R10 below start err", {31'h0, err}, 32'h1);
        @(negedge clk);
        check("R10 tail unchanged", ram[128], {12'h000, 4'h2, 16'h0018});
        check("R10 target unchanged", ram[192], 32'h0);
        run_req(1'b1, 16'h0065, 4'h1, 12'hFF0, 13'd8);
        check("R10 end at 4088 ok", {31'h0, err}, 32'h0);
        clear_ram();
        run_req(1'b1, 16'h0066, 4'h1, 12'h300, 13'd8);
        check("R10 empty chain err", {31'h0, err}, 32'h1);
        @(negedge clk);
        check("R10 empty chain no write", ram[192], 32'h0);
        // identifier 0 inside the chain blocks insertion
        clear_ram();
        poke(256, {12'h140, 4'h1, 16'h0000});
        poke(320, {12'h000, 4'h1, 16'h0007});
        run_req(1'b1, 16'h0067, 4'h1, 12'h300, 13'd8);
        check("R10 zero id err", {31'h0, err}, 32'h1);
        @(negedge clk);
        check("R10 zero id no write", ram[80], {12'h000, 4'h1, 16'h0007});

        // R11: request strobed while busy is dropped
        build_std();
        start_req(1'b0, 16'h0018, 4'h0, 12'h0, 13'h0);
        check("R11 busy", {31'h0, busy}, 32'h1);
        req_valid = 1'b1; req_append = 1'b1; req_id = 16'h0077;
        req_off = 12'h400; req_size = 13'd8;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        check("R11 first result kept", {20'h0, res_off}, 32'h200);
        check("R11 busy low at done", {31'h0, busy}, 32'h0);
        @(negedge clk);
        check("R11 done one cycle", {31'h0, done}, 32'h0);
        check("R11 result held", {20'h0, res_prev}, 32'h140);
        repeat (10) @(negedge clk);
        check("R11 dropped insert no write", ram[256], 32'h0);
        check("R11 tail unchanged", ram[128], {12'h000, 4'h2, 16'h0018});

        summary_and_end();
    end
endmodule